// File: doc/BRIEF.md
# Split Data/MAC Authentication Buffer

This block sits on the receive side of a shared bus that carries an encrypted cache line and its message authentication code as two separate bus transactions. A line arrives first and is decrypted at once with the pad supplied alongside it. The plaintext goes straight to consumers, together with a tag that names the buffer slot holding its pending check. The MAC for that line may turn up several transactions later, with other lines and other MACs in between, and in any order relative to other MACs.

Each slot keeps the transaction ID, the locally computed MAC, a pad word for decrypting the incoming MAC, and valid and verified flags. When a MAC beat arrives, the block looks for the pending slot with the same ID. It decrypts the received MAC with that slot's stored pad and compares the result with the local MAC. A match pulses a verify-done event carrying the slot index and releases the slot. A mismatch pulses a failure event with the index and drops the slot. A MAC that finds no slot raises an orphan event. The local MAC is a keyed XOR fold rather than a full cryptographic MAC. When every slot holds an unverified line, the block withdraws its ready signal and asserts backpressure.

Top module: `auth_buf_top`

## Requirements
- R1: After reset, bus_rdy is 1, bus_bp is 0, no event output is high, and no slot holds a line, so any MAC beat is reported as an orphan.
- R2: A data beat with dat_vld high while bus_rdy is high takes the lowest-indexed free slot. One cycle later, alloc_vld pulses with alloc_tag equal to that index, and plain_line equals dat_line XOR the low LINE_W bits of dat_pad.
- R3: The local MAC is the XOR of all MAC_W-bit slices of the plaintext, XOR mac_key, XOR dat_seq zero-extended to MAC_W. The received mac_val is decrypted by XOR with the top MAC_W bits of the dat_pad recorded for that ID.
- R4: A MAC beat whose decrypted value equals the local MAC of the pending slot with the same ID pulses done_vld for one cycle, one cycle later, with done_tag equal to that slot index. The slot counts as free again from the next cycle.
- R5: A MAC beat that finds its slot but does not match pulses fail_vld for one cycle, one cycle later, with fail_tag equal to the slot index. The slot is released and no done_vld occurs.
- R6: A MAC beat whose ID is held by no pending slot pulses orphan_vld one cycle later, with neither done_vld nor fail_vld. A MAC beat in the same cycle as the data beat of its own ID is an orphan.
- R7: When all ENTRIES slots hold unverified lines, bus_rdy is 0 and bus_bp is 1. A data beat offered then is ignored: no alloc_vld and no slot is taken.
- R8: MAC beats are matched by ID alone, so they may arrive in any order and interleaved with data beats. When two pending slots share an ID, the lower index is matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mac_key | input | MAC_W | Secret key mixed into the local MAC |
| dat_vld | input | 1 | Data beat present |
| dat_id | input | ID_W | Transaction ID of the data beat |
| dat_seq | input | SEQ_W | Bus sequence number of the data beat |
| dat_line | input | LINE_W | Encrypted line |
| dat_pad | input | LINE_W+MAC_W | Pad: low part decrypts the line, top MAC_W bits decrypt the later MAC |
| mac_vld | input | 1 | MAC beat present |
| mac_id | input | ID_W | Transaction ID the MAC belongs to |
| mac_val | input | MAC_W | Encrypted MAC |
| bus_rdy | output | 1 | Buffer can accept a data beat |
| bus_bp | output | 1 | Backpressure to the bus, all slots pending |
| alloc_vld | output | 1 | A slot was allocated |
| alloc_tag | output | TAG_W | Index of the allocated slot |
| plain_line | output | LINE_W | Decrypted line, valid with alloc_vld |
| done_vld | output | 1 | MAC verified |
| done_tag | output | TAG_W | Slot index that was verified |
| fail_vld | output | 1 | MAC mismatch |
| fail_tag | output | TAG_W | Slot index that failed |
| orphan_vld | output | 1 | MAC with no pending slot |

## Verification
The bench builds the block with ENTRIES=4, LINE_W=64, MAC_W=32, ID_W=4 and SEQ_W=8. Four slots let a short run fill the buffer and hit backpressure, offer a line that must be dropped, and then show that a dropped ID has no slot. The 64-bit line folds into two 32-bit halves, so the fold, the key, the sequence term and the MAC pad are all exercised with small values that the bench works out itself.

// File: rtl/auth_buf_pkg.sv
package auth_buf_pkg;

  typedef enum logic [1:0] {
    MR_NONE   = 2'd0,
    MR_PASS   = 2'd1,
    MR_FAIL   = 2'd2,
    MR_ORPHAN = 2'd3
  } mac_res_e;

endpackage

// File: rtl/auth_buf_pick.sv
module auth_buf_pick #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // lowest set bit wins
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/auth_buf_fold.sv
module auth_buf_fold #(
  parameter int IN_W  = 256,
  parameter int OUT_W = 64
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int SLICES = IN_W / OUT_W;

  logic [OUT_W-1:0] part [SLICES];

  for (genvar k = 0; k < SLICES; k++) begin : g_slice
    assign part[k] = din[k*OUT_W +: OUT_W];
  end

  always_comb begin
    dout = '0;
    for (int k = 0; k < SLICES; k++) dout = dout ^ part[k];
  end
endmodule

// File: rtl/auth_buf_top.sv
module auth_buf_top
  import auth_buf_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ID_W    = 8,
  parameter int SEQ_W   = 16,
  parameter int LINE_W  = 256,
  parameter int MAC_W   = 64,
  parameter int TAG_W   = $clog2(ENTRIES),
  parameter int PAD_W   = LINE_W + MAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MAC_W-1:0]  mac_key,
  input  logic              dat_vld,
  input  logic [ID_W-1:0]   dat_id,
  input  logic [SEQ_W-1:0]  dat_seq,
  input  logic [LINE_W-1:0] dat_line,
  input  logic [PAD_W-1:0]  dat_pad,
  input  logic              mac_vld,
  input  logic [ID_W-1:0]   mac_id,
  input  logic [MAC_W-1:0]  mac_val,
  output logic              bus_rdy,
  output logic              bus_bp,
  output logic              alloc_vld,
  output logic [TAG_W-1:0]  alloc_tag,
  output logic [LINE_W-1:0] plain_line,
  output logic              done_vld,
  output logic [TAG_W-1:0]  done_tag,
  output logic              fail_vld,
  output logic [TAG_W-1:0]  fail_tag,
  output logic              orphan_vld
);

  // slot state
  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [ENTRIES-1:0] ver_q, ver_d;
  logic [ID_W-1:0]    ent_id  [ENTRIES];
  logic [MAC_W-1:0]   ent_mac [ENTRIES];
  logic [MAC_W-1:0]   ent_pad [ENTRIES];

  logic [ENTRIES-1:0] pend, free_vec, hit_vec;
  logic               full, take;
  logic               free_any, hit_any;
  logic [TAG_W-1:0]   free_idx, hit_idx;

  // arrival datapath
  logic [LINE_W-1:0]  plain_c;
  logic [MAC_W-1:0]   fold_c, local_mac_c, rx_mac_c;
  logic               mac_ok;

  // registered outputs
  logic               alloc_q;
  logic [TAG_W-1:0]   alloc_tag_q;
  logic [LINE_W-1:0]  plain_q;
  mac_res_e           res_q, res_d;
  logic [TAG_W-1:0]   res_tag_q;

  assign pend     = vld_q & ~ver_q;
  assign free_vec = ~pend;
  assign full     = &pend;
  assign take     = dat_vld & ~full;

  assign bus_rdy  = ~full;
  assign bus_bp   = full;

  auth_buf_pick #(.N(ENTRIES), .IDX_W(TAG_W)) u_free_pick (
    .req (free_vec),
    .any (free_any),
    .idx (free_idx)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_match
    assign hit_vec[i] = pend[i] && (ent_id[i] == mac_id);
  end

  auth_buf_pick #(.N(ENTRIES), .IDX_W(TAG_W)) u_hit_pick (
    .req (hit_vec),
    .any (hit_any),
    .idx (hit_idx)
  );

  assign plain_c = dat_line ^ dat_pad[LINE_W-1:0];

  auth_buf_fold #(.IN_W(LINE_W), .OUT_W(MAC_W)) u_fold (
    .din  (plain_c),
    .dout (fold_c)
  );

  assign local_mac_c = fold_c ^ mac_key ^ {{(MAC_W-SEQ_W){1'b0}}, dat_seq};
  assign rx_mac_c    = mac_val ^ ent_pad[hit_idx];
  assign mac_ok      = (rx_mac_c == ent_mac[hit_idx]);

  // next-state
  always_comb begin
    vld_d = vld_q;
    ver_d = ver_q;
    res_d = MR_NONE;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ver_q[i]) begin
        vld_d[i] = 1'b0;
        ver_d[i] = 1'b0;
      end
    end
    if (mac_vld) begin
      if (!hit_any) begin
        res_d = MR_ORPHAN;
      end else if (mac_ok) begin
        res_d          = MR_PASS;
        ver_d[hit_idx] = 1'b1;
      end else begin
        res_d          = MR_FAIL;
        vld_d[hit_idx] = 1'b0;
      end
    end
    if (take) begin
      vld_d[free_idx] = 1'b1;
      ver_d[free_idx] = 1'b0;
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q       <= '0;
      ver_q       <= '0;
      alloc_q     <= 1'b0;
      alloc_tag_q <= '0;
      res_q       <= MR_NONE;
      res_tag_q   <= '0;
    end else begin
      vld_q       <= vld_d;
      ver_q       <= ver_d;
      alloc_q     <= take;
      if (take) alloc_tag_q <= free_idx;
      res_q       <= res_d;
      if (mac_vld) res_tag_q <= hit_idx;
    end
  end

  // payload registers, enabled, no reset
  always_ff @(posedge clk) begin
    if (take) begin
      ent_id[free_idx]  <= dat_id;
      ent_mac[free_idx] <= local_mac_c;
      ent_pad[free_idx] <= dat_pad[PAD_W-1 -: MAC_W];
      plain_q           <= plain_c;
    end
  end

  assign alloc_vld  = alloc_q;
  assign alloc_tag  = alloc_tag_q;
  assign plain_line = plain_q;
  assign done_vld   = (res_q == MR_PASS);
  assign fail_vld   = (res_q == MR_FAIL);
  assign orphan_vld = (res_q == MR_ORPHAN);
  assign done_tag   = res_tag_q;
  assign fail_tag   = res_tag_q;

  // assertions

  // R7
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rdy) |=> !alloc_vld);

  // R2
  alloc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_vld |-> ($past(dat_vld) && $past(free_any)));

  // R5
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_vld, fail_vld, orphan_vld}));

  // R4
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld |-> $past(mac_vld));

  // R6
  orphan_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    orphan_vld |-> $past(mac_vld));

  // R1
  rdy_bp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdy != bus_bp);

  // R2
  alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> vld_q[alloc_tag] && !ver_q[alloc_tag]);

endmodule

// File: tb/auth_buf_top_tb_top.sv
`timescale 1ns/1ps
module auth_buf_top_tb_top;

  localparam int ENTRIES = 4;
  localparam int ID_W    = 4;
  localparam int SEQ_W   = 8;
  localparam int LINE_W  = 64;
  localparam int MAC_W   = 32;
  localparam int TAG_W   = 2;
  localparam int PAD_W   = LINE_W + MAC_W;
  localparam logic [MAC_W-1:0] KEY = 32'hC0FF_EE11;

  // kinds: 0 data accepted, 1 data dropped, 2 MAC good, 3 MAC bad, 4 MAC orphan
  // vector: {kind[2:0], id[3:0], tag[1:0], rdy_after}
  localparam logic [9:0] VEC [12] = '{
    {3'd0, 4'd1, 2'd0, 1'b1},
    {3'd0, 4'd2, 2'd1, 1'b1},
    {3'd0, 4'd3, 2'd2, 1'b1},
    {3'd2, 4'd1, 2'd0, 1'b1},
    {3'd0, 4'd4, 2'd0, 1'b1},
    {3'd3, 4'd3, 2'd2, 1'b1},
    {3'd4, 4'd9, 2'd0, 1'b1},
    {3'd0, 4'd5, 2'd2, 1'b1},
    {3'd0, 4'd6, 2'd3, 1'b0},
    {3'd1, 4'd7, 2'd0, 1'b0},
    {3'd2, 4'd2, 2'd1, 1'b1},
    {3'd4, 4'd7, 2'd0, 1'b1}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              dat_vld, mac_vld;
  logic [ID_W-1:0]   dat_id, mac_id;
  logic [SEQ_W-1:0]  dat_seq;
  logic [LINE_W-1:0] dat_line;
  logic [PAD_W-1:0]  dat_pad;
  logic [MAC_W-1:0]  mac_val;
  logic              bus_rdy, bus_bp, alloc_vld, done_vld, fail_vld, orphan_vld;
  logic [TAG_W-1:0]  alloc_tag, done_tag, fail_tag;
  logic [LINE_W-1:0] plain_line;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  auth_buf_top #(
    .ENTRIES(ENTRIES), .ID_W(ID_W), .SEQ_W(SEQ_W),
    .LINE_W(LINE_W), .MAC_W(MAC_W), .TAG_W(TAG_W), .PAD_W(PAD_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .mac_key(KEY),
    .dat_vld(dat_vld), .dat_id(dat_id), .dat_seq(dat_seq),
    .dat_line(dat_line), .dat_pad(dat_pad),
    .mac_vld(mac_vld), .mac_id(mac_id), .mac_val(mac_val),
    .bus_rdy(bus_rdy), .bus_bp(bus_bp),
    .alloc_vld(alloc_vld), .alloc_tag(alloc_tag), .plain_line(plain_line),
    .done_vld(done_vld), .done_tag(done_tag),
    .fail_vld(fail_vld), .fail_tag(fail_tag), .orphan_vld(orphan_vld)
  );

  function automatic logic [LINE_W-1:0] mk_line(input logic [ID_W-1:0] id);
    return {16{id}} ^ 64'h0123_4567_89AB_CDEF;
  endfunction
  function automatic logic [PAD_W-1:0] mk_pad(input logic [ID_W-1:0] id);
    return {24{id}} ^ 96'hF0E1_D2C3_B4A5_9687_7869_5A4B;
  endfunction
  function automatic logic [SEQ_W-1:0] mk_seq(input logic [ID_W-1:0] id);
    return {4'h0, id} + 8'h10;
  endfunction
  // R3: encrypted MAC a correct sender would put on the bus
  function automatic logic [MAC_W-1:0] mk_mac(input logic [ID_W-1:0] id);
    logic [LINE_W-1:0] p;
    logic [PAD_W-1:0]  pd;
    pd = mk_pad(id);
    p  = mk_line(id) ^ pd[LINE_W-1:0];
    return p[31:0] ^ p[63:32] ^ KEY ^ {24'h0, mk_seq(id)} ^ pd[PAD_W-1 -: MAC_W];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    dat_vld = 1'b0; mac_vld = 1'b0;
    dat_id = '0; dat_seq = '0; dat_line = '0; dat_pad = '0;
    mac_id = '0; mac_val = '0;
  endtask

  task automatic drive_data(input logic [ID_W-1:0] id);
    dat_vld = 1'b1; dat_id = id; dat_seq = mk_seq(id);
    dat_line = mk_line(id); dat_pad = mk_pad(id);
  endtask

  task automatic drive_mac(input logic [ID_W-1:0] id, input bit corrupt);
    mac_vld = 1'b1; mac_id = id;
    mac_val = mk_mac(id) ^ {31'h0, corrupt};
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [PAD_W-1:0] pd;
    do_reset();

    // R1 reset state
    chk(bus_rdy == 1'b1, "R1", "rdy", 64'(bus_rdy), 64'd1);
    chk(bus_bp == 1'b0, "R1", "bp", 64'(bus_bp), 64'd0);
    chk({alloc_vld, done_vld, fail_vld, orphan_vld} == 4'b0, "R1", "events",
        64'({alloc_vld, done_vld, fail_vld, orphan_vld}), 64'd0);

    // table walk: interleaved data and out-of-order MACs (R8)
    for (int v = 0; v < 12; v++) begin
      logic [2:0]      kind;
      logic [ID_W-1:0] id;
      logic [TAG_W-1:0] tag;
      logic            rdy;
      {kind, id, tag, rdy} = VEC[v];
      case (kind)
        3'd0, 3'd1: drive_data(id);
        3'd2:       drive_mac(id, 1'b0);
        3'd3:       drive_mac(id, 1'b1);
        default:    drive_mac(id, 1'b0);
      endcase
      @(negedge clk);
      case (kind)
        3'd0: begin
          pd = mk_pad(id);
          chk(alloc_vld == 1'b1, "R2", "alloc_vld", 64'(alloc_vld), 64'd1);
          chk(alloc_tag == tag, "R2", "alloc_tag", 64'(alloc_tag), 64'(tag));
          chk(plain_line == (mk_line(id) ^ pd[LINE_W-1:0]), "R2", "plain",
              plain_line, mk_line(id) ^ pd[LINE_W-1:0]);
        end
        3'd1: chk(alloc_vld == 1'b0, "R7", "dropped alloc", 64'(alloc_vld), 64'd0);
        3'd2: begin
          chk(done_vld == 1'b1 && fail_vld == 1'b0, "R4", "done_vld",
              64'({done_vld, fail_vld}), 64'h2);
          chk(done_tag == tag, "R8", "done_tag", 64'(done_tag), 64'(tag));
        end
        3'd3: begin
          chk(fail_vld == 1'b1 && done_vld == 1'b0, "R5", "fail_vld",
              64'({fail_vld, done_vld}), 64'h2);
          chk(fail_tag == tag, "R5", "fail_tag", 64'(fail_tag), 64'(tag));
        end
        default:
          chk({orphan_vld, done_vld, fail_vld} == 3'b100, "R6", "orphan",
              64'({orphan_vld, done_vld, fail_vld}), 64'h4);
      endcase
      chk(bus_rdy == rdy && bus_bp == !rdy, "R7", "rdy/bp",
          64'({bus_rdy, bus_bp}), 64'({rdy, !rdy}));
      idle();
    end

    // R1: reset mid-run empties the buffer; a MAC for a held ID is orphan
    do_reset();
    drive_mac(4'd4, 1'b0);
    @(negedge clk);
    chk(orphan_vld == 1'b1, "R1", "orphan after reset", 64'(orphan_vld), 64'd1);
    idle();

    // R6: MAC in the same cycle as its own data is orphan; data still allocated
    drive_data(4'd11);
    drive_mac(4'd11, 1'b0);
    @(negedge clk);
    chk(orphan_vld == 1'b1, "R6", "same-cycle orphan", 64'(orphan_vld), 64'd1);
    chk(alloc_vld == 1'b1 && alloc_tag == 2'd0, "R2", "alloc same cycle",
        64'({alloc_vld, alloc_tag}), 64'h4);
    idle();

    // R8: duplicate ID matches the lower slot; R3 checked via good MAC
    drive_data(4'd11);
    @(negedge clk);
    chk(alloc_tag == 2'd1, "R8", "dup alloc_tag", 64'(alloc_tag), 64'd1);
    idle();
    drive_mac(4'd11, 1'b0);
    @(negedge clk);
    chk(done_vld == 1'b1 && done_tag == 2'd0, "R8", "dup lower slot",
        64'({done_vld, done_tag}), 64'h4);
    idle();
    drive_mac(4'd11, 1'b0);
    @(negedge clk);
    chk(done_vld == 1'b1 && done_tag == 2'd1, "R3", "second dup verified",
        64'({done_vld, done_tag}), 64'h5);
    idle();
    @(negedge clk);
    chk(done_vld == 1'b0, "R4", "done is one pulse", 64'(done_vld), 64'd0);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule